// File: doc/BRIEF.md
# EEPROM write-protection sequencer

This block sits in front of an EEPROM array controller and decides, byte by byte, whether a host write may reach the array. It holds a software protection flag that is set out of reset. While the flag is set, an array write goes through only after a short unlock command sequence. Each command byte is a fixed data value written to a fixed offset. Longer sequences clear the flag or open a lockout-mask register. The mask holds one bit per 1K-byte block, and a block whose bit is set can never be written.

Command bytes are recognised on the low twelve address bits. The three address bits above the array address must match a configured value. Each byte of a sequence, and each byte of the page write that follows an unlock, must arrive within a byte-load window measured in clock cycles. Otherwise the sequence is abandoned. While the array is busy with a write cycle, every host write is ignored and any partial sequence is dropped.

Top module: `eeg_top`

## Requirements
- R1: After reset, sdp_o is 1, mask_o is all zeros and wr_open_o is 0.
- R2: With sdp_o at 1 and no window open, a plain write gives no arr_we_o pulse. With sdp_o at 0, a plain write to an unlocked block raises arr_we_o in the cycle of the write.
- R3: The bytes AA at offset 555, 55 at offset AAA and A0 at offset 555, written in that order, open a write window (wr_open_o=1). Bytes written while the window is open raise arr_we_o. The A0 step also sets sdp_o to 1.
- R4: A command byte matches only when addr_i[11:0] equals the offset and addr_i[15:13] equals cfg_hi_i. addr_i[12] is ignored.
- R5: A sequence or an open window survives a gap of up to WIN_CYC (16) clock edges between accepted writes. A longer gap returns the block to idle (wr_open_o=0).
- R6: A byte that does not match the expected step returns the sequence to idle and is not written. No command-sequence byte ever raises arr_we_o, whatever the state of sdp_o.
- R7: The sequence AA@555, 55@AAA, 80@555, AA@555, 55@AAA, 20@555 clears sdp_o and leaves mask_o unchanged.
- R8: The sequence AA@555, 55@AAA, 80@555, AA@555, 55@AAA, C0@555 makes the next write load mask_o from data_i. Bit i of mask_o locks block i, where block i is addr_i[12:10]=i. That write pulses mask_we_o, does not raise arr_we_o, and sets sdp_o to 1.
- R9: A write to a locked block never raises arr_we_o, whether it comes inside an open window or while sdp_o is 0.
- R10: While busy_i is 1, writes have no effect, arr_we_o and mask_we_o stay 0, and any sequence or window returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe, one byte per cycle |
| addr_i | input | 16 | Host write address |
| data_i | input | 8 | Host write data |
| busy_i | input | 1 | Array write cycle in progress |
| cfg_hi_i | input | 3 | Configured value of address bits 15:13 for command bytes |
| arr_we_o | output | 1 | Write enable to the array, same cycle as the host write |
| mask_we_o | output | 1 | Lockout mask register is being loaded |
| sdp_o | output | 1 | Software protection flag |
| wr_open_o | output | 1 | Unlock write window is open |
| mask_o | output | 8 | Block lockout mask |

## Verification
Two things can land on the same clock edge: the arrival of a sequence byte and the closing of the byte-load window. The bench provokes this by placing the next byte exactly WIN_CYC edges after the previous one, where the byte must win, and one edge later, where the timeout must win. The second collision is a write strobe that coincides with busy_i while the window is open. That byte must be dropped and the window must be closed at the next edge. Both collisions are judged on arr_we_o in the cycle of the write and on wr_open_o after the edge.

// File: rtl/eeg_pkg.sv
package eeg_pkg;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 12;

  localparam logic [OFS_W-1:0]  OFS_A = 12'h555;
  localparam logic [OFS_W-1:0]  OFS_B = 12'hAAA;
  localparam logic [DATA_W-1:0] C_AA  = 8'hAA;
  localparam logic [DATA_W-1:0] C_55  = 8'h55;
  localparam logic [DATA_W-1:0] C_A0  = 8'hA0;
  localparam logic [DATA_W-1:0] C_80  = 8'h80;
  localparam logic [DATA_W-1:0] C_20  = 8'h20;
  localparam logic [DATA_W-1:0] C_C0  = 8'hC0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_S1, ST_S2, ST_OPEN, ST_S3, ST_S4, ST_S5, ST_MASK
  } seq_st_e;

  typedef struct packed {
    logic aa_a;
    logic b55_b;
    logic a0_a;
    logic b80_a;
    logic b20_a;
    logic c0_a;
  } cmd_hit_t;
endpackage

// File: rtl/eeg_cmd_match.sv
module eeg_cmd_match
  import eeg_pkg::*;
#(
  parameter int HI_W = 3
) (
  input  logic [HI_W-1:0]   hi_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [HI_W-1:0]   cfg_hi_i,
  output cmd_hit_t          hit_o
);
  logic hi_ok, at_a, at_b;

  assign hi_ok = (hi_i == cfg_hi_i);
  assign at_a  = hi_ok && (ofs_i == OFS_A);
  assign at_b  = hi_ok && (ofs_i == OFS_B);

  always_comb begin
    hit_o.aa_a  = at_a && (data_i == C_AA);
    hit_o.b55_b = at_b && (data_i == C_55);
    hit_o.a0_a  = at_a && (data_i == C_A0);
    hit_o.b80_a = at_a && (data_i == C_80);
    hit_o.b20_a = at_a && (data_i == C_20);
    hit_o.c0_a  = at_a && (data_i == C_C0);
  end
endmodule

// File: rtl/eeg_seq_fsm.sv
module eeg_seq_fsm
  import eeg_pkg::*;
#(
  parameter int WIN_CYC = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic     busy_i,
  input  cmd_hit_t hit_i,
  output logic     pass_o,
  output logic     mask_ld_o,
  output logic     sdp_o,
  output logic     open_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  seq_st_e          st_q, st_d;
  logic             sdp_q, sdp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_ok;

  assign wr_ok = wr_i && !busy_i;

  always_comb begin
    st_d  = st_q;
    sdp_d = sdp_q;
    if (busy_i) begin
      st_d = ST_IDLE;
    end else if (wr_i) begin
      unique case (st_q)
        ST_IDLE: if (hit_i.aa_a) st_d = ST_S1;
        ST_S1:   st_d = hit_i.b55_b ? ST_S2 : ST_IDLE;
        ST_S2: begin
          if (hit_i.a0_a) begin
            st_d  = ST_OPEN;
            sdp_d = 1'b1;
          end else if (hit_i.b80_a) begin
            st_d = ST_S3;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_OPEN: st_d = ST_OPEN;
        ST_S3:   st_d = hit_i.aa_a  ? ST_S4 : ST_IDLE;
        ST_S4:   st_d = hit_i.b55_b ? ST_S5 : ST_IDLE;
        ST_S5: begin
          if (hit_i.b20_a) begin
            st_d  = ST_IDLE;
            sdp_d = 1'b0;
          end else if (hit_i.c0_a) begin
            st_d = ST_MASK;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_MASK: begin
          st_d  = ST_IDLE;
          sdp_d = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end else if (st_q != ST_IDLE && cnt_q == CNT_W'(WIN_CYC - 1)) begin
      st_d = ST_IDLE;  // byte-load window expired
    end
  end

  assign cnt_d = (wr_ok || busy_i || st_d == ST_IDLE) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sdp_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      sdp_q <= sdp_d;
      cnt_q <= cnt_d;
    end
  end

  assign pass_o    = wr_ok && ((st_q == ST_IDLE && !sdp_q && !hit_i.aa_a) ||
                               st_q == ST_OPEN);
  assign mask_ld_o = wr_ok && (st_q == ST_MASK);
  assign sdp_o     = sdp_q;
  assign open_o    = (st_q == ST_OPEN);

  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (cnt_q < CNT_W'(WIN_CYC))); // R5
  AST_BUSY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!open_o && !mask_ld_o)); // R10
endmodule

// File: rtl/eeg_lock_mask.sv
module eeg_lock_mask #(
  parameter int NUM_BLK = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [IDX_W-1:0]   blk_i,
  output logic               hit_o,
  output logic [NUM_BLK-1:0] mask_o
);
  logic [NUM_BLK-1:0] mask_d;

  assign mask_d = NUM_BLK'(data_i);

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   mask_o[i] <= 1'b0;
      else if (ld_i) mask_o[i] <= mask_d[i];
    end
  end

  assign hit_o = mask_o[blk_i];

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(mask_o)); // R8
endmodule

// File: rtl/eeg_top.sv
module eeg_top
  import eeg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int HI_W    = 3,
  parameter int ARR_W   = 13,
  parameter int BLK_W   = 10,
  parameter int WIN_CYC = 16,
  localparam int NUM_BLK = 1 << (ARR_W - BLK_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               busy_i,
  input  logic [HI_W-1:0]    cfg_hi_i,
  output logic               arr_we_o,
  output logic               mask_we_o,
  output logic               sdp_o,
  output logic               wr_open_o,
  output logic [NUM_BLK-1:0] mask_o
);
  cmd_hit_t hit;
  logic     pass, lock_hit;

  eeg_cmd_match #(.HI_W(HI_W)) i_match (
    .hi_i     (addr_i[ADDR_W-1 -: HI_W]),
    .ofs_i    (addr_i[OFS_W-1:0]),
    .data_i   (data_i),
    .cfg_hi_i (cfg_hi_i),
    .hit_o    (hit)
  );

  eeg_seq_fsm #(.WIN_CYC(WIN_CYC)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .busy_i    (busy_i),
    .hit_i     (hit),
    .pass_o    (pass),
    .mask_ld_o (mask_we_o),
    .sdp_o     (sdp_o),
    .open_o    (wr_open_o)
  );

  eeg_lock_mask #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (mask_we_o),
    .data_i (data_i),
    .blk_i  (addr_i[ARR_W-1:BLK_W]),
    .hit_o  (lock_hit),
    .mask_o (mask_o)
  );

  assign arr_we_o = pass && !lock_hit;

  AST_ARR_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> (!sdp_o || wr_open_o)); // R2
  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!arr_we_o && !mask_we_o)); // R10
  AST_MASK_SDP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_o |=> sdp_o); // R8
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_we_o && mask_we_o)); // R8
  AST_DEACT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdp_o) |-> $stable(mask_o)); // R7
endmodule

// File: tb/test_eeg_top.sv
`timescale 1ns/1ps
module test_eeg_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        busy_i = 1'b0;
  logic [2:0]  cfg_hi_i = '0;
  logic        arr_we_o, mask_we_o, sdp_o, wr_open_o;
  logic [7:0]  mask_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] hi = 16'h0000;

  always #5 clk_i = ~clk_i;

  eeg_top i_eeg_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .data_i(data_i), .busy_i(busy_i), .cfg_hi_i(cfg_hi_i),
    .arr_we_o(arr_we_o), .mask_we_o(mask_we_o), .sdp_o(sdp_o),
    .wr_open_o(wr_open_o), .mask_o(mask_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d,
                    input logic ea, input logic em, input string tag);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; data_i = d;
    #1;
    chk({tag, " arr_we"}, 8'(arr_we_o), 8'(ea));
    chk({tag, " mask_we"}, 8'(mask_we_o), 8'(em));
    @(posedge clk_i);
    #1 wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic cmd(input logic [11:0] ofs, input logic [7:0] d, input string tag);
    wr(hi | 16'(ofs), d, 1'b0, 1'b0, tag);
  endtask

  task automatic unlock(input string tag);
    cmd(12'h555, 8'hAA, tag); cmd(12'hAAA, 8'h55, tag); cmd(12'h555, 8'hA0, tag);
  endtask

  task automatic six(input logic [7:0] last, input string tag);
    cmd(12'h555, 8'hAA, tag); cmd(12'hAAA, 8'h55, tag); cmd(12'h555, 8'h80, tag);
    cmd(12'h555, 8'hAA, tag); cmd(12'hAAA, 8'h55, tag); cmd(12'h555, last, tag);
  endtask

  task automatic t_reset;
    chk("R1 sdp", 8'(sdp_o), 8'd1);
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 open", 8'(wr_open_o), 8'd0);
  endtask

  task automatic t_plain_blocked;
    wr(16'h0100, 8'h12, 1'b0, 1'b0, "R2 plain with sdp");
  endtask

  task automatic t_unlock;
    unlock("R6 unlock bytes");
    chk("R3 open", 8'(wr_open_o), 8'd1);
    wr(16'h0C00, 8'h11, 1'b1, 1'b0, "R3 first byte");
    wr(16'h0C01, 8'h22, 1'b1, 1'b0, "R3 page byte");
    idle(16);
    chk("R5 window closed", 8'(wr_open_o), 8'd0);
    wr(16'h0C02, 8'h33, 1'b0, 1'b0, "R5 after close");
  endtask

  task automatic t_window_edge;
    cmd(12'h555, 8'hAA, "R5 edge"); idle(15);
    cmd(12'hAAA, 8'h55, "R5 edge"); idle(15);
    cmd(12'h555, 8'hA0, "R5 edge"); idle(15);
    wr(16'h0C00, 8'h44, 1'b1, 1'b0, "R5 gap at limit");
    idle(20);
    cmd(12'h555, 8'hAA, "R5 late"); idle(16);
    cmd(12'hAAA, 8'h55, "R5 late"); cmd(12'h555, 8'hA0, "R5 late");
    chk("R5 late open", 8'(wr_open_o), 8'd0);
    wr(16'h0C00, 8'h45, 1'b0, 1'b0, "R5 gap over limit");
  endtask

  task automatic t_hi;
    cfg_hi_i = 3'b101;
    wr(16'hB555, 8'hAA, 1'b0, 1'b0, "R4 cmd");
    wr(16'hBAAA, 8'h55, 1'b0, 1'b0, "R4 cmd");
    wr(16'hA555, 8'hA0, 1'b0, 1'b0, "R4 cmd");
    wr(16'h0C00, 8'h55, 1'b1, 1'b0, "R4 hi match, a12 ignored");
    idle(20);
    unlock("R4 wrong hi");
    chk("R4 wrong hi open", 8'(wr_open_o), 8'd0);
    wr(16'h0C00, 8'h56, 1'b0, 1'b0, "R4 wrong hi data");
    cfg_hi_i = 3'b000;
    idle(20);
  endtask

  task automatic t_mismatch;
    cmd(12'h555, 8'hAA, "R6 mm");
    cmd(12'hAAA, 8'h56, "R6 bad byte");
    cmd(12'h555, 8'hA0, "R6 mm");
    chk("R6 not open", 8'(wr_open_o), 8'd0);
    wr(16'h0C00, 8'h66, 1'b0, 1'b0, "R6 data after mismatch");
  endtask

  task automatic t_busy;
    unlock("R10 pre");
    busy_i = 1'b1;
    wr(16'h0C00, 8'h77, 1'b0, 1'b0, "R10 write while busy");
    chk("R10 window dropped", 8'(wr_open_o), 8'd0);
    busy_i = 1'b0;
    wr(16'h0C00, 8'h78, 1'b0, 1'b0, "R10 after busy");
  endtask

  task automatic t_mask;
    six(8'hC0, "R8 open");
    wr(16'h0000, 8'h05, 1'b0, 1'b1, "R8 mask load");
    chk("R8 mask", mask_o, 8'h05);
    chk("R8 sdp", 8'(sdp_o), 8'd1);
    unlock("R9 pre");
    wr(16'h0010, 8'h01, 1'b0, 1'b0, "R9 block0 locked");
    wr(16'h0410, 8'h02, 1'b1, 1'b0, "R9 block1 free");
    wr(16'h0810, 8'h03, 1'b0, 1'b0, "R9 block2 locked");
    idle(20);
  endtask

  task automatic t_deact;
    six(8'h20, "R7 seq");
    chk("R7 sdp cleared", 8'(sdp_o), 8'd0);
    chk("R7 mask kept", mask_o, 8'h05);
    wr(16'h0C00, 8'h88, 1'b1, 1'b0, "R2 plain with sdp off");
    wr(16'h0000, 8'h89, 1'b0, 1'b0, "R9 locked with sdp off");
    cmd(12'h555, 8'hAA, "R6 cmd byte sdp off");
    cmd(12'hAAA, 8'h12, "R6 mismatch sdp off");
    wr(16'h0C00, 8'h8A, 1'b1, 1'b0, "R6 back to idle");
    unlock("R3 relock");
    chk("R3 sdp set", 8'(sdp_o), 8'd1);
    idle(20);
    wr(16'h0C00, 8'h8B, 1'b0, 1'b0, "R2 blocked again");
  endtask

  initial begin
    #100_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_plain_blocked();
    t_unlock();
    t_window_edge();
    t_hi();
    t_mismatch();
    t_busy();
    t_mask();
    t_deact();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule